// File: doc/BRIEF.md
# Second-Order Recursive Filter Section (Direct Form II)

This block is one second-order IIR section in Direct Form II. It takes one signed 16-bit sample each time `in_valid` is accepted and returns one filtered 16-bit sample with a one-cycle `out_valid` pulse. A single two-entry state line holds the intermediate values w(n-1) and w(n-2). The feedback path and the feed-forward path both read from that line.

Each sample is processed in two steps. The first step, the feedback step, forms w(n) = x(n) - a1*w(n-1) - a2*w(n-2). The second step, the feed-forward step, forms y(n) = b0*w(n) + b1*w(n-1) + b2*w(n-2). Every multiply produces a full 32-bit product. The sums are kept two bits wider so that adding them cannot wrap. Each sum is scaled back by the coefficient fraction width and clamped to 16 bits, both before w(n) enters the state line and before y(n) leaves the block.

The five coefficients are written one at a time through a small write port. The block takes the next sample only after the previous output has been produced.

Top module: `biquad_df2`

## Requirements
- R1: After a synchronous reset (`rst` high at a rising edge), the following values hold. `out_valid` is 0, `in_ready` is 1 and `out_data` is 0. Both state entries are 0. The coefficients are b0 = 16384 (1.0) and b1 = b2 = a1 = a2 = 0, so each sample passes through unchanged.
- R2: The coefficients are 16-bit signed Q2.14 values. A write with `coef_we` high stores `coef_wdata` into one coefficient, chosen by `coef_sel`: 0 = b0, 1 = b1, 2 = b2, 3 = a1, 4 = a2. The new value is in use from the next cycle. Writes with `coef_sel` equal to 5, 6 or 7 change nothing.
- R3: The intermediate value is w(n) = clamp(floor((x*16384 - a1*w(n-1) - a2*w(n-2)) / 16384)). The clamp limits the result to the range -32768..32767.
- R4: The output is y(n) = clamp(floor((b0*w(n) + b1*w(n-1) + b2*w(n-2)) / 16384)). It uses the same w(n-1) and w(n-2) values as the feedback step of that sample.
- R5: After each output, the state line shifts: w(n-1) moves to w(n-2) and the clamped w(n) becomes w(n-1). The state persists from one sample to the next.
- R6: A sample is accepted at a rising edge where `in_valid` and `in_ready` are both high. `out_valid` goes high after the third rising edge that follows, counting the accepting edge as the first. It stays high for exactly one cycle, and `in_ready` is high again in that same cycle.
- R7: A y(n) that falls outside the 16-bit range is output as 32767 or -32768. A w(n) that falls outside the range is stored and reused as 32767 or -32768.
- R8: While `in_ready` is low, `in_valid` and `in_data` have no effect on any output or on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coef_we | input | 1 | Coefficient write enable |
| coef_sel | input | 3 | Coefficient select (0=b0, 1=b1, 2=b2, 3=a1, 4=a2) |
| coef_wdata | input | 16 | Coefficient value, signed Q2.14 |
| in_valid | input | 1 | Input sample strobe |
| in_ready | output | 1 | High when a new sample can be accepted |
| in_data | input | 16 | Input sample, signed |
| out_valid | output | 1 | One-cycle pulse when `out_data` holds a new result |
| out_data | output | 16 | Filtered sample, signed |

## Verification
A corrupted state entry has no effect on the sample in flight. It shows up in `out_data` on the next sample through the b1 and b2 terms, and on the sample after that through the w(n-2) term. Because the filter is recursive, the error then persists in every later output. For this reason the bench compares every output against a model that carries its own copy of the state, across long runs under four coefficient sets. When b0 is 1.0 and b1 = b2 = 0, w(n) appears directly at `out_data`, so a wrong clamp on the stored state shows up in that same output pulse.

// File: rtl/biquad_pkg.sv
package biquad_pkg;

  // Processing step of one sample
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_FB   = 2'd1,
    PH_FF   = 2'd2
  } phase_e;

  // Coefficient slots, selected by the write port
  localparam int unsigned COEF_NUM = 5;
  localparam int unsigned IDX_B0   = 0;
  localparam int unsigned IDX_B1   = 1;
  localparam int unsigned IDX_B2   = 2;
  localparam int unsigned IDX_A1   = 3;
  localparam int unsigned IDX_A2   = 4;

endpackage

// File: rtl/biquad_coef_bank.sv
module biquad_coef_bank #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FRAC   = 14,
  parameter int unsigned SEL_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [SEL_W-1:0]         sel,
  input  logic [DATA_W-1:0]        wdata,
  output logic signed [DATA_W-1:0] b0,
  output logic signed [DATA_W-1:0] b1,
  output logic signed [DATA_W-1:0] b2,
  output logic signed [DATA_W-1:0] a1,
  output logic signed [DATA_W-1:0] a2
);
  import biquad_pkg::*;

  localparam logic [DATA_W-1:0] UNITY = DATA_W'(1 << FRAC);

  logic [COEF_NUM-1:0][DATA_W-1:0] coef_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < COEF_NUM; k++)
        coef_q[k] <= (k == IDX_B0) ? UNITY : '0;
    end else if (we) begin
      for (int k = 0; k < COEF_NUM; k++)
        if (sel == SEL_W'(k)) coef_q[k] <= wdata;
    end
  end

  assign b0 = $signed(coef_q[IDX_B0]);
  assign b1 = $signed(coef_q[IDX_B1]);
  assign b2 = $signed(coef_q[IDX_B2]);
  assign a1 = $signed(coef_q[IDX_A1]);
  assign a2 = $signed(coef_q[IDX_A2]);

  wire sel_out_of_range = (32'(sel) >= COEF_NUM);

  genvar g;
  generate
    for (g = 0; g < COEF_NUM; g++) begin : g_wr_chk
      // R2
      coef_write_chk: assert property (@(posedge clk) disable iff (rst)
        (we && sel == SEL_W'(g)) |=> (coef_q[g] == $past(wdata)));
    end
  endgenerate

  // R2
  coef_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (we && sel_out_of_range) |=> $stable(coef_q));

endmodule

// File: rtl/biquad_delay_line.sv
module biquad_delay_line #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TAPS   = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         shift,
  input  logic [DATA_W-1:0]            din,
  output logic [TAPS-1:0][DATA_W-1:0]  taps
);

  logic [TAPS-1:0][DATA_W-1:0] tap_q;

  always_ff @(posedge clk) begin
    if (rst)        tap_q <= '0;
    else if (shift) tap_q <= {tap_q[TAPS-2:0], din};
  end

  assign taps = tap_q;

  genvar g;
  generate
    for (g = 1; g < TAPS; g++) begin : g_shift_chk
      // R5
      tap_move_chk: assert property (@(posedge clk) disable iff (rst)
        shift |=> (tap_q[g] == $past(tap_q[g-1])));
    end
  endgenerate

  // R5
  tap_enter_chk: assert property (@(posedge clk) disable iff (rst)
    shift |=> (tap_q[0] == $past(din)));

  // R8
  tap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift |=> $stable(tap_q));

endmodule

// File: rtl/biquad_arith.sv
module biquad_arith #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FRAC   = 14
) (
  input  logic signed [DATA_W-1:0] x,
  input  logic signed [DATA_W-1:0] w_cur,
  input  logic signed [DATA_W-1:0] w1,
  input  logic signed [DATA_W-1:0] w2,
  input  logic signed [DATA_W-1:0] b0,
  input  logic signed [DATA_W-1:0] b1,
  input  logic signed [DATA_W-1:0] b2,
  input  logic signed [DATA_W-1:0] a1,
  input  logic signed [DATA_W-1:0] a2,
  output logic signed [DATA_W-1:0] w_next,
  output logic signed [DATA_W-1:0] y_next,
  output logic                     w_ovf_hi,
  output logic                     w_ovf_lo,
  output logic                     y_ovf_hi,
  output logic                     y_ovf_lo
);

  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam int unsigned ACC_W  = PROD_W + 2;

  localparam logic signed [ACC_W-1:0] ACC_MAX = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] ACC_MIN = -ACC_MAX - ACC_W'(1);

  function automatic logic signed [PROD_W-1:0] mul(input logic signed [DATA_W-1:0] c,
                                                   input logic signed [DATA_W-1:0] d);
    return PROD_W'(c) * PROD_W'(d);
  endfunction

  function automatic logic above(input logic signed [ACC_W-1:0] acc);
    return (acc >>> FRAC) > ACC_MAX;
  endfunction

  function automatic logic below(input logic signed [ACC_W-1:0] acc);
    return (acc >>> FRAC) < ACC_MIN;
  endfunction

  // Scale back by the fraction width (floor), then clamp to sample width
  function automatic logic signed [DATA_W-1:0] reduce(input logic signed [ACC_W-1:0] acc);
    logic signed [ACC_W-1:0] scaled;
    scaled = acc >>> FRAC;
    if (scaled > ACC_MAX)      return ACC_MAX[DATA_W-1:0];
    else if (scaled < ACC_MIN) return ACC_MIN[DATA_W-1:0];
    else                       return scaled[DATA_W-1:0];
  endfunction

  logic signed [PROD_W-1:0] x_scaled;
  logic signed [ACC_W-1:0]  acc_fb;
  logic signed [ACC_W-1:0]  acc_ff;

  assign x_scaled = PROD_W'(x) <<< FRAC;

  assign acc_fb = ACC_W'(x_scaled) - ACC_W'(mul(a1, w1)) - ACC_W'(mul(a2, w2));
  assign acc_ff = ACC_W'(mul(b0, w_cur)) + ACC_W'(mul(b1, w1)) + ACC_W'(mul(b2, w2));

  assign w_next   = reduce(acc_fb);
  assign y_next   = reduce(acc_ff);
  assign w_ovf_hi = above(acc_fb);
  assign w_ovf_lo = below(acc_fb);
  assign y_ovf_hi = above(acc_ff);
  assign y_ovf_lo = below(acc_ff);

endmodule

// File: rtl/biquad_df2.sv
module biquad_df2 #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FRAC   = 14,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              coef_we,
  input  logic [SEL_W-1:0]  coef_sel,
  input  logic [DATA_W-1:0] coef_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  import biquad_pkg::*;

  localparam int unsigned TAPS = 2;
  localparam logic [DATA_W-1:0] S_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] S_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  phase_e                      phase_q;
  logic signed [DATA_W-1:0]    x_q, w_q, y_q;
  logic                        out_valid_q;
  logic [TAPS-1:0][DATA_W-1:0] taps;

  logic signed [DATA_W-1:0] c_b0, c_b1, c_b2, c_a1, c_a2;
  logic signed [DATA_W-1:0] w_next, y_next;
  logic w_ovf_hi, w_ovf_lo, y_ovf_hi, y_ovf_lo;

  // Named internal events
  wire accept  = in_valid && in_ready;
  wire fb_step = (phase_q == PH_FB);
  wire ff_step = (phase_q == PH_FF);

  biquad_coef_bank #(.DATA_W(DATA_W), .FRAC(FRAC), .SEL_W(SEL_W)) u_coef (
    .clk(clk), .rst(rst), .we(coef_we), .sel(coef_sel), .wdata(coef_wdata),
    .b0(c_b0), .b1(c_b1), .b2(c_b2), .a1(c_a1), .a2(c_a2)
  );

  biquad_delay_line #(.DATA_W(DATA_W), .TAPS(TAPS)) u_state (
    .clk(clk), .rst(rst), .shift(ff_step), .din(w_q), .taps(taps)
  );

  biquad_arith #(.DATA_W(DATA_W), .FRAC(FRAC)) u_arith (
    .x(x_q), .w_cur(w_q), .w1($signed(taps[0])), .w2($signed(taps[1])),
    .b0(c_b0), .b1(c_b1), .b2(c_b2), .a1(c_a1), .a2(c_a2),
    .w_next(w_next), .y_next(y_next),
    .w_ovf_hi(w_ovf_hi), .w_ovf_lo(w_ovf_lo),
    .y_ovf_hi(y_ovf_hi), .y_ovf_lo(y_ovf_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      x_q         <= '0;
      w_q         <= '0;
      y_q         <= '0;
      out_valid_q <= 1'b0;
    end else begin
      out_valid_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (accept) begin
          x_q     <= $signed(in_data);
          phase_q <= PH_FB;
        end
        PH_FB: begin
          w_q     <= w_next;
          phase_q <= PH_FF;
        end
        PH_FF: begin
          y_q         <= y_next;
          out_valid_q <= 1'b1;
          phase_q     <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign in_ready  = (phase_q == PH_IDLE);
  assign out_valid = out_valid_q;
  assign out_data  = y_q;

  // R6
  out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> ##3 out_valid);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !ff_step) |=> $stable(x_q));

  // R7
  w_sat_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (fb_step && w_ovf_hi) |=> (w_q == S_MAX));

  // R7
  w_sat_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (fb_step && w_ovf_lo) |=> (w_q == S_MIN));

  // R7
  y_sat_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (ff_step && y_ovf_hi) |=> (out_data == S_MAX));

  // R7
  y_sat_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (ff_step && y_ovf_lo) |=> (out_data == S_MIN));

endmodule

// File: tb/biquad_df2_test.sv
`timescale 1ns/1ps
module biquad_df2_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        coef_we = 1'b0;
  logic [2:0]  coef_sel = '0;
  logic [15:0] coef_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [15:0] out_data;

  int checks = 0;
  int fails  = 0;

  // Model state
  longint mc[5];
  longint m_w1, m_w2;
  bit     seen_hi, seen_lo;

  always #4 clk = ~clk;

  biquad_df2 uut (
    .clk(clk), .rst(rst), .coef_we(coef_we), .coef_sel(coef_sel),
    .coef_wdata(coef_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint clamp16(input longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // Model: feedback, then feed-forward, then state shift
  function automatic longint model_step(input longint x);
    longint acc, w, y;
    acc = x * 16384 - mc[3] * m_w1 - mc[4] * m_w2;
    w   = clamp16(acc >>> 14);
    acc = mc[0] * w + mc[1] * m_w1 + mc[2] * m_w2;
    y   = clamp16(acc >>> 14);
    m_w2 = m_w1;
    m_w1 = w;
    return y;
  endfunction

  task automatic write_coef(input int sel, input longint val);
    coef_we    = 1'b1;
    coef_sel   = 3'(sel);
    coef_wdata = 16'(val);
    @(negedge clk);
    coef_we = 1'b0;
    if (sel < 5) mc[sel] = val;
  endtask

  // Sends one sample starting at a negedge; optional junk while busy (R8)
  task automatic send(input longint x, input bit junk);
    longint exp;
    exp = model_step(x);
    in_valid = 1'b1;
    in_data  = 16'(x);
    @(negedge clk);
    if (junk) begin
      in_data = 16'(x ^ 16'h5a5a);
    end else begin
      in_valid = 1'b0;
    end
    check(!out_valid && !in_ready, "R6/R8 busy after accept", {out_valid, in_ready}, 0);
    @(negedge clk);
    check(!out_valid, "R6 no early result", out_valid, 0);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && in_ready, "R6 result pulse", {out_valid, in_ready}, 3);
    check($signed(out_data) == exp, "R3/R4/R5 output value", $signed(out_data), exp);
    if (exp == 32767)  seen_hi = 1'b1;
    if (exp == -32768) seen_lo = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R6 single pulse", {out_valid, in_ready}, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    longint sets[4][5];
    sets[0] = '{4096, 8192, 4096, -8192, 4096};
    sets[1] = '{16384, 0, 0, -26000, 12000};
    sets[2] = '{32767, 32767, 32767, -32768, 16384};
    sets[3] = '{-16384, 20000, -8000, 12000, -9000};
    mc = '{16384, 0, 0, 0, 0};
    m_w1 = 0;
    m_w2 = 0;
    seen_hi = 0;
    seen_lo = 0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(!out_valid, "R1 out_valid after reset", out_valid, 0);
    check(in_ready, "R1 in_ready after reset", in_ready, 1);
    check(out_data == 16'd0, "R1 out_data after reset", $signed(out_data), 0);

    // R1: pass-through with reset coefficients, extremes included
    send(-32768, 0);
    send(32767, 0);
    send(-1, 1);
    send(0, 0);
    send(12345, 0);

    // R2: unused selectors change nothing, output stays pass-through
    write_coef(5, 999);
    write_coef(6, -5000);
    write_coef(7, 32767);
    send(-20000, 0);
    send(7, 0);

    // Sweep over coefficient sets; state carries across sets (R5)
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 5; k++) write_coef(k, sets[s][k]);
      // R5: impulse then zeros exposes the stored state
      send(16000, 0);
      for (int i = 0; i < 6; i++) send(0, 0);
      // Spread across the input range, with busy-time junk on some
      for (int i = 0; i < 48; i++) begin
        longint xv;
        xv = longint'((i * 7919 + s * 1237) % 65536) - 32768;
        send(xv, (i % 5) == 0);
      end
      // Held steps of both signs
      for (int i = 0; i < 8; i++) send(30000, 0);
      for (int i = 0; i < 8; i++) send(-30000, i[0]);
    end

    // R7: both clamp levels reached and matched the model
    check(seen_hi, "R7 positive clamp observed", seen_hi, 1);
    check(seen_lo, "R7 negative clamp observed", seen_lo, 1);

    // R1: reset mid-run restores pass-through and clears the state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mc = '{16384, 0, 0, 0, 0};
    m_w1 = 0;
    m_w2 = 0;
    check(out_data == 16'd0 && in_ready, "R1 second reset", $signed(out_data), 0);
    send(-4321, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule